// File: doc/BRIEF.md
# Addressed Peripheral Read Port

This block lets a single peripheral answer read requests from a bus master on a shared processor bus. Every peripheral on the bus owns one register and one 4-bit address, so up to sixteen of them can share the same strobe, address and data lines. While no read is aimed at it, the port keeps copying the peripheral's live register value into a private snapshot register on every clock, and it leaves the shared data lines undriven.

When the master raises the read strobe with an address equal to this port's own address, the port takes a final snapshot on that clock edge and starts driving it onto the data lines. The snapshot stays frozen for the whole read, even if the live value keeps changing. The port keeps driving until the master drops the strobe, and then it releases the lines on the next edge. The own address is an input, so it can come from strapping pins or from another register. It is compared again on every cycle.

The control is a two-state machine. **IDLE** captures the snapshot and keeps the lines released. **SEND** drives the snapshot and holds it. There are four transitions:
- *accept*: IDLE to SEND, taken on strobe high together with an address match.
- *ignore*: IDLE to IDLE, taken in any other case while idle.
- *hold*: SEND to SEND, taken while the strobe stays high.
- *release*: SEND to IDLE, taken when the strobe is low.

Top module: `periph_read_port`

## Requirements
- R1: While `rst` is high at a clock edge, the port enters IDLE. `data_oe` is 0 after that edge.
- R2: In IDLE, `data_oe` is 0 and `bus_data` is high-impedance.
- R3: An edge in IDLE with `rd_strobe`=1 and `bus_addr`==`own_addr` moves the port to SEND (accept). `data_oe` is 1 after that edge.
- R4: An edge in IDLE with `rd_strobe`=0, or with `bus_addr`!=`own_addr`, keeps the port in IDLE (ignore).
- R5: The value driven in SEND equals `reg_value` as sampled at the accepting edge.
- R6: In SEND the snapshot is not reloaded. `bus_data` stays constant even when `reg_value` changes.
- R7: In SEND with `rd_strobe`=1, the port stays in SEND (hold), whatever `bus_addr` is.
- R8: An edge in SEND with `rd_strobe`=0 returns the port to IDLE (release). `data_oe` is 0 after that edge.
- R9: `own_addr` is read on every cycle. After a change to it, the next accept decision uses the new value.
- R10: While `data_oe` is 1, `bus_data` carries the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | Read request from the bus master |
| bus_addr | input | 4 | Address the master is reading |
| own_addr | input | 4 | This peripheral's address |
| reg_value | input | 32 | Live value of the peripheral's register |
| bus_data | output | 32 | Shared data lines (high-impedance when not driving) |
| data_oe | output | 1 | High while the port drives `bus_data` |

## Verification
The assertions check every state transition (accept, ignore, hold and release) on every cycle. They also check that the snapshot tracks `reg_value` while loading and stays frozen while not loading, and that reset clears the output enable. Some behaviours can only be shown by the bench's scenarios, because they are observed at the ports:
- the exact value seen on `bus_data` during a read;
- the effect of changing `own_addr` between reads;
- back-to-back reads;
- an address change during a read that must be ignored.

// File: rtl/prp_pkg.sv
package prp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } prp_state_e;
endpackage

// File: rtl/prp_datapath.sv
module prp_datapath #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] reg_value,
    input  logic              snap_ld,
    output logic              addr_hit,
    output logic [DATA_W-1:0] snap_q
);
    // address comparator
    always_comb begin
        addr_hit = (bus_addr == own_addr);
    end

    // snapshot register with load enable
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (snap_ld) begin
            snap_q <= reg_value;
        end
    end

    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        snap_ld |=> snap_q == $past(reg_value)); // R5
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !snap_ld |=> snap_q == $past(snap_q)); // R6
endmodule

// File: rtl/prp_fsm.sv
module prp_fsm
    import prp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_strobe,
    input  logic addr_hit,
    output logic snap_ld,
    output logic drive_en
);
    prp_state_e state_q, state_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_strobe && addr_hit) state_d = ST_SEND; // accept
            ST_SEND: if (!rd_strobe)            state_d = ST_IDLE; // release
            default:                            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        snap_ld  = 1'b0;
        drive_en = 1'b0;
        unique case (state_q)
            ST_IDLE: snap_ld  = 1'b1;
            ST_SEND: drive_en = 1'b1;
            default: snap_ld  = 1'b1;
        endcase
    end

    AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && rd_strobe && addr_hit) |=> state_q == ST_SEND); // R3
    AST_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !(rd_strobe && addr_hit)) |=> state_q == ST_IDLE); // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND && rd_strobe) |=> state_q == ST_SEND); // R7
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND && !rd_strobe) |=> state_q == ST_IDLE); // R8
endmodule

// File: rtl/periph_read_port.sv
module periph_read_port #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] reg_value,
    output logic [DATA_W-1:0] bus_data,
    output logic              data_oe
);
    logic              addr_hit;
    logic              snap_ld;
    logic              drive_en;
    logic [DATA_W-1:0] snap_q;

    prp_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .own_addr (own_addr),
        .reg_value(reg_value),
        .snap_ld  (snap_ld),
        .addr_hit (addr_hit),
        .snap_q   (snap_q)
    );

    prp_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rd_strobe(rd_strobe),
        .addr_hit (addr_hit),
        .snap_ld  (snap_ld),
        .drive_en (drive_en)
    );

    assign data_oe  = drive_en;
    assign bus_data = drive_en ? snap_q : {DATA_W{1'bz}};

    AST_RESET_OE: assert property (@(posedge clk)
        rst |=> !data_oe); // R1
    AST_IDLE_NO_LOAD_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !(snap_ld && drive_en)); // R2
endmodule

// File: tb/periph_read_port_tb.sv
module periph_read_port_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_strobe;
    logic [3:0]  bus_addr;
    logic [3:0]  own_addr;
    logic [31:0] reg_value;
    logic [31:0] bus_data;
    logic        data_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    periph_read_port dut_i (
        .clk      (clk),
        .rst      (rst),
        .rd_strobe(rd_strobe),
        .bus_addr (bus_addr),
        .own_addr (own_addr),
        .reg_value(reg_value),
        .bus_data (bus_data),
        .data_oe  (data_oe)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_oe(input string req, input logic exp);
        chk(data_oe === exp, req, {31'd0, data_oe}, {31'd0, exp});
    endtask

    task automatic chk_data(input string req, input logic [31:0] exp);
        chk(data_oe === 1'b1 && bus_data === exp, req, bus_data, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; rd_strobe = 1'b0; bus_addr = 4'h0; own_addr = 4'h5; reg_value = 32'h0;
        tick(); tick();
        chk_oe("R1 reset", 1'b0);
        rst = 1'b0;
        tick();
        chk_oe("R2 idle released", 1'b0);
    endtask

    task automatic t_basic_read();
        reg_value = 32'hA1B2_C3D4; bus_addr = 4'h5; rd_strobe = 1'b1;
        tick();
        chk_oe("R3 accept", 1'b1);
        chk_data("R5 snapshot", 32'hA1B2_C3D4);
        reg_value = 32'h1111_2222;
        tick();
        chk_data("R6 frozen", 32'hA1B2_C3D4);
        reg_value = 32'h3333_4444;
        tick();
        chk_data("R10 driven value", 32'hA1B2_C3D4);
        rd_strobe = 1'b0;
        tick();
        chk_oe("R8 release", 1'b0);
    endtask

    task automatic t_mismatch();
        bus_addr = 4'h6; rd_strobe = 1'b1; reg_value = 32'h5555_6666;
        tick(); tick();
        chk_oe("R4 wrong address", 1'b0);
        bus_addr = 4'h5; rd_strobe = 1'b0;
        tick();
        chk_oe("R4 no strobe", 1'b0);
        // idle kept loading: a read now shows the latest value
        reg_value = 32'h7777_8888; rd_strobe = 1'b1;
        tick();
        chk_data("R5 latest value", 32'h7777_8888);
        rd_strobe = 1'b0;
        tick();
    endtask

    task automatic t_hold_addr_change();
        reg_value = 32'hDEAD_BEEF; bus_addr = 4'h5; rd_strobe = 1'b1;
        tick();
        bus_addr = 4'h9;
        tick(); tick();
        chk_oe("R7 hold", 1'b1);
        chk_data("R7 hold data", 32'hDEAD_BEEF);
        rd_strobe = 1'b0;
        tick();
        chk_oe("R8 release after hold", 1'b0);
    endtask

    task automatic t_own_addr_change();
        own_addr = 4'hC; bus_addr = 4'h5; rd_strobe = 1'b1; reg_value = 32'h0BAD_F00D;
        tick();
        chk_oe("R9 old address ignored", 1'b0);
        bus_addr = 4'hC;
        tick();
        chk_data("R9 new address accepted", 32'h0BAD_F00D);
        rd_strobe = 1'b0;
        tick();
    endtask

    task automatic t_back_to_back();
        bus_addr = 4'hC; rd_strobe = 1'b1; reg_value = 32'h0000_0001;
        tick();
        chk_data("R3 first read", 32'h0000_0001);
        rd_strobe = 1'b0; reg_value = 32'h0000_0002;
        tick();
        chk_oe("R8 gap", 1'b0);
        rd_strobe = 1'b1; reg_value = 32'h0000_0003;
        tick();
        chk_data("R5 second read", 32'h0000_0003);
        rst = 1'b1;
        tick();
        chk_oe("R1 reset mid read", 1'b0);
        rst = 1'b0; rd_strobe = 1'b0;
        tick();
    endtask

    initial begin
        t_reset();
        t_basic_read();
        t_mismatch();
        t_hold_addr_change();
        t_own_addr_change();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule